// File: doc/BRIEF.md
# I2C Multi-Address Acknowledge and Software Reset Decoder

This block sits beside an I2C target byte engine and decides, for every received byte, whether the target should drive an acknowledge. The first byte after a START is an address byte. The block compares its upper seven bits against several candidates at the same time:
- the fixed hardware address, which is always active;
- one broadcast address, which has its own enable bit;
- a parameterised number of group addresses, each with its own enable bit.

When any of them matches, the block gives a single acknowledge. It then keeps acknowledging the data bytes of a write. During a read it stays silent, because in a read the controller acknowledges.

The block also watches for a software-reset call. This is a write to a dedicated reset address, followed by the key bytes A5h and 5Ah. If a STOP then arrives, the block raises a one-cycle register-reset pulse, which the register file uses to return every register to its default and to release the LED outputs to high impedance. The byte engine supplies decoded START and STOP events and received bytes with a valid strobe. Register contents arrive as plain inputs.

Top module: `i2cm_match_top`

## Requirements
- R1: An address byte whose bits 7:1 equal the hardware address is acknowledged, whether its bit 0 (the direction bit, 1 = read, 0 = write) is 0 or 1.
- R2: The broadcast address is acknowledged only while its enable is 1. Only bits 7:1 of its register are compared, and register bit 0 has no effect.
- R3: Each group address is acknowledged only while its own enable bit is 1. Only bits 7:1 of each 8-bit register are compared, and register bit 0 has no effect.
- R4: An address byte that matches no enabled candidate receives a decision with acknowledge 0.
- R5: The reset call address (bits 7:1 = 0000011b, i.e. byte 06h) is acknowledged with bit 0 = 0. With bit 0 = 1 it is not acknowledged, even when another candidate holds the same value.
- R6: After an acknowledged reset call, the next byte is acknowledged only if it equals A5h. Any other value gets acknowledge 0 and ends the sequence.
- R7: After A5h, a byte equal to 5Ah is acknowledged and arms the reset. Any other value gets acknowledge 0 and the reset is not armed.
- R8: When STOP arrives while the reset is armed, `reg_rst_o` pulses high for exactly one cycle, in the cycle after the STOP. Any extra byte or a repeated START before the STOP cancels the reset.
- R9: After an acknowledged write address, every data byte is acknowledged. After an acknowledged read address, after a rejected address, or before any START, bytes produce no decision (`ack_vld_o` stays 0).
- R10: `ack_vld_o` and `ack_o` are valid in the cycle after `byte_vld_i`. `ack_o` is 1 only together with `ack_vld_o`. After reset all outputs are 0.
- R11: When several candidates match the same address byte, exactly one acknowledge decision with value 1 is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt_i | input | 1 | START or repeated START detected (one cycle) |
| stop_evt_i | input | 1 | STOP detected (one cycle) |
| byte_vld_i | input | 1 | Received byte valid (one cycle) |
| byte_i | input | 8 | Received byte |
| hw_addr_i | input | 7 | Hardware target address |
| bcast_addr_i | input | 8 | Broadcast address register (bits 7:1 used) |
| bcast_en_i | input | 1 | Broadcast address enable |
| grp_addr_i | input | 8*NUM_GRP | Group address registers, group k in bits 8k+7:8k |
| grp_en_i | input | NUM_GRP | Group address enables, bit k for group k |
| ack_vld_o | output | 1 | Acknowledge decision valid |
| ack_o | output | 1 | Acknowledge (1) or not (0) |
| reg_rst_o | output | 1 | One-cycle register reset pulse |

## Verification
The bench targets the reset key sequence at every point where it can break:
- A wrong first or second key makes a design that only checks the address reset on any STOP.
- A third byte after the key exposes a design that keeps the reset armed.
- A repeated START between the key and the STOP catches a design that fires on the STOP of the following transfer.
- A read to the reset address must be refused even when a group register holds the same address; a design with the wrong priority acknowledges it.

Group and broadcast registers are loaded with bit 0 set and with their enables toggled. This exposes comparisons that include bit 0 or ignore the enables. Read transfers check that no decision is given for data bytes that the controller acknowledges.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WR,
        ST_RD,
        ST_KEY1,
        ST_KEY2,
        ST_ARMED,
        ST_SKIP
    } seq_st_e;

    typedef struct packed {
        seq_st_e st;
        logic    dec_vld;
        logic    dec_ack;
        logic    rst_pls;
    } seq_reg_t;

    localparam logic [7:0] KEY_FIRST_DEF  = 8'hA5;
    localparam logic [7:0] KEY_SECOND_DEF = 8'h5A;
    localparam logic [6:0] RST_CALL_DEF   = 7'h03;

endpackage

// File: rtl/i2cm_addr_cmp.sv
module i2cm_addr_cmp #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] cand_i,
    input  logic          en_i,
    input  logic [AW-1:0] rx_i,
    output logic          hit_o
);
    always_comb begin
        hit_o = en_i && (cand_i == rx_i);
    end
endmodule

// File: rtl/i2cm_addr_match.sv
module i2cm_addr_match #(
    parameter int         NUM_GRP  = 3,
    parameter logic [6:0] RST_CALL = i2cm_pkg::RST_CALL_DEF
) (
    input  logic [6:0]           rx_addr_i,
    input  logic [6:0]           hw_addr_i,
    input  logic [7:0]           bcast_addr_i,
    input  logic                 bcast_en_i,
    input  logic [8*NUM_GRP-1:0] grp_addr_i,
    input  logic [NUM_GRP-1:0]   grp_en_i,
    output logic                 any_hit_o,
    output logic                 rst_hit_o
);
    localparam int NCAND = NUM_GRP + 2;

    logic [NCAND-1:0] hits;
    logic             unused_lsbs;

    i2cm_addr_cmp #(.AW(7)) u_hw (
        .cand_i (hw_addr_i),
        .en_i   (1'b1),
        .rx_i   (rx_addr_i),
        .hit_o  (hits[0])
    );

    i2cm_addr_cmp #(.AW(7)) u_bcast (
        .cand_i (bcast_addr_i[7:1]),
        .en_i   (bcast_en_i),
        .rx_i   (rx_addr_i),
        .hit_o  (hits[1])
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        i2cm_addr_cmp #(.AW(7)) u_grp (
            .cand_i (grp_addr_i[8*g+7 -: 7]),
            .en_i   (grp_en_i[g]),
            .rx_i   (rx_addr_i),
            .hit_o  (hits[g+2])
        );
    end

    always_comb begin
        any_hit_o   = |hits;
        rst_hit_o   = (rx_addr_i == RST_CALL);
        unused_lsbs = bcast_addr_i[0];
        for (int g = 0; g < NUM_GRP; g++) begin
            unused_lsbs = unused_lsbs ^ grp_addr_i[8*g];
        end
    end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter logic [7:0] KEY_FIRST  = KEY_FIRST_DEF,
    parameter logic [7:0] KEY_SECOND = KEY_SECOND_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_evt_i,
    input  logic       stop_evt_i,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    input  logic       any_hit_i,
    input  logic       rst_hit_i,
    output logic       dec_vld_o,
    output logic       dec_ack_o,
    output logic       rst_pls_o
);
    seq_reg_t q, d;

    always_comb begin
        d         = q;
        d.dec_vld = 1'b0;
        d.dec_ack = 1'b0;
        d.rst_pls = 1'b0;
        if (start_evt_i) begin
            d.st = ST_ADDR;
        end else if (stop_evt_i) begin
            d.rst_pls = (q.st == ST_ARMED);
            d.st      = ST_IDLE;
        end else if (byte_vld_i) begin
            unique case (q.st)
                ST_ADDR: begin
                    d.dec_vld = 1'b1;
                    if (rst_hit_i) begin
                        d.dec_ack = !byte_i[0];
                        d.st      = byte_i[0] ? ST_SKIP : ST_KEY1;
                    end else if (any_hit_i) begin
                        d.dec_ack = 1'b1;
                        d.st      = byte_i[0] ? ST_RD : ST_WR;
                    end else begin
                        d.st = ST_SKIP;
                    end
                end
                ST_WR: begin
                    d.dec_vld = 1'b1;
                    d.dec_ack = 1'b1;
                end
                ST_KEY1: begin
                    d.dec_vld = 1'b1;
                    d.dec_ack = (byte_i == KEY_FIRST);
                    d.st      = (byte_i == KEY_FIRST) ? ST_KEY2 : ST_SKIP;
                end
                ST_KEY2: begin
                    d.dec_vld = 1'b1;
                    d.dec_ack = (byte_i == KEY_SECOND);
                    d.st      = (byte_i == KEY_SECOND) ? ST_ARMED : ST_SKIP;
                end
                ST_ARMED: begin
                    d.dec_vld = 1'b1;
                    d.st      = ST_SKIP;
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, dec_vld: 1'b0, dec_ack: 1'b0, rst_pls: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign dec_vld_o = q.dec_vld;
    assign dec_ack_o = q.dec_ack;
    assign rst_pls_o = q.rst_pls;
endmodule

// File: rtl/i2cm_match_top.sv
module i2cm_match_top #(
    parameter int NUM_GRP = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_evt_i,
    input  logic                 stop_evt_i,
    input  logic                 byte_vld_i,
    input  logic [7:0]           byte_i,
    input  logic [6:0]           hw_addr_i,
    input  logic [7:0]           bcast_addr_i,
    input  logic                 bcast_en_i,
    input  logic [8*NUM_GRP-1:0] grp_addr_i,
    input  logic [NUM_GRP-1:0]   grp_en_i,
    output logic                 ack_vld_o,
    output logic                 ack_o,
    output logic                 reg_rst_o
);
    logic any_hit;
    logic rst_hit;

    i2cm_addr_match #(
        .NUM_GRP  (NUM_GRP),
        .RST_CALL (i2cm_pkg::RST_CALL_DEF)
    ) u_match (
        .rx_addr_i    (byte_i[7:1]),
        .hw_addr_i    (hw_addr_i),
        .bcast_addr_i (bcast_addr_i),
        .bcast_en_i   (bcast_en_i),
        .grp_addr_i   (grp_addr_i),
        .grp_en_i     (grp_en_i),
        .any_hit_o    (any_hit),
        .rst_hit_o    (rst_hit)
    );

    i2cm_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_evt_i (start_evt_i),
        .stop_evt_i  (stop_evt_i),
        .byte_vld_i  (byte_vld_i),
        .byte_i      (byte_i),
        .any_hit_i   (any_hit),
        .rst_hit_i   (rst_hit),
        .dec_vld_o   (ack_vld_o),
        .dec_ack_o   (ack_o),
        .rst_pls_o   (reg_rst_o)
    );
endmodule

// File: rtl/i2cm_match_chk.sv
module i2cm_match_chk (
    input logic clk,
    input logic rst_n,
    input logic start_evt_i,
    input logic stop_evt_i,
    input logic byte_vld_i,
    input logic ack_vld_o,
    input logic ack_o,
    input logic reg_rst_o
);
    // R8: reset pulse lasts one cycle
    p_rst_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rst_o |=> !reg_rst_o);

    // R8: reset pulse only in the cycle after a STOP
    p_rst_after_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rst_o |-> $past(stop_evt_i));

    // R8: a START in the prior cycle never yields a pulse
    p_no_rst_on_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rst_o |-> !$past(start_evt_i));

    // R10: acknowledge only together with a decision
    p_ack_needs_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ack_vld_o);

    // R10: a decision follows a received byte by one cycle
    p_vld_after_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld_o |-> $past(byte_vld_i));

    // R10: decision and reset pulse never coincide
    p_vld_rst_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_vld_o && reg_rst_o));
endmodule

bind i2cm_match_top i2cm_match_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_evt_i (start_evt_i),
    .stop_evt_i  (stop_evt_i),
    .byte_vld_i  (byte_vld_i),
    .ack_vld_o   (ack_vld_o),
    .ack_o       (ack_o),
    .reg_rst_o   (reg_rst_o)
);

// File: tb/i2cm_match_top_tb.sv
module i2cm_match_top_tb_top;
    localparam int NG = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_evt_i = 1'b0;
    logic          stop_evt_i = 1'b0;
    logic          byte_vld_i = 1'b0;
    logic [7:0]    byte_i = 8'h00;
    logic [6:0]    hw_addr_i = 7'h62;
    logic [7:0]    bcast_addr_i = 8'hE1;
    logic          bcast_en_i = 1'b0;
    logic [8*NG-1:0] grp_addr_i = {8'hE9, 8'hE5, 8'hE3};
    logic [NG-1:0] grp_en_i = '0;
    logic          ack_vld_o;
    logic          ack_o;
    logic          reg_rst_o;

    int n_chk = 0;
    int n_fail = 0;
    int ms = 0; // 0 idle,1 addr,2 wr,3 rd,4 key1,5 key2,6 armed,7 skip
    bit done = 0;

    always #5 clk = ~clk;

    i2cm_match_top #(.NUM_GRP(NG)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_evt_i(start_evt_i), .stop_evt_i(stop_evt_i),
        .byte_vld_i(byte_vld_i), .byte_i(byte_i), .hw_addr_i(hw_addr_i),
        .bcast_addr_i(bcast_addr_i), .bcast_en_i(bcast_en_i), .grp_addr_i(grp_addr_i),
        .grp_en_i(grp_en_i), .ack_vld_o(ack_vld_o), .ack_o(ack_o), .reg_rst_o(reg_rst_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit model_hit(input logic [7:0] b);
        bit h = (b[7:1] == hw_addr_i);
        if (bcast_en_i && b[7:1] == bcast_addr_i[7:1]) h = 1;
        for (int g = 0; g < NG; g++)
            if (grp_en_i[g] && b[7:1] == grp_addr_i[8*g+1 +: 7]) h = 1;
        return h;
    endfunction

    task automatic send_start();
        @(negedge clk);
        start_evt_i = 1'b1;
        @(negedge clk);
        start_evt_i = 1'b0;
        ms = 1;
        check(reg_rst_o == 1'b0 && ack_vld_o == 1'b0, "R8 start", reg_rst_o, 0);
    endtask

    task automatic send_stop(input string tag);
        bit exp_r = (ms == 6);
        @(negedge clk);
        stop_evt_i = 1'b1;
        @(negedge clk);
        stop_evt_i = 1'b0;
        ms = 0;
        check(reg_rst_o == exp_r, {tag, " R8 pulse"}, reg_rst_o, exp_r);
        @(negedge clk);
        check(reg_rst_o == 1'b0, {tag, " R8 width"}, reg_rst_o, 0);
    endtask

    task automatic send_byte(input logic [7:0] b, input string tag);
        bit ev = 0, ea = 0;
        case (ms)
            1: begin
                ev = 1;
                if (b[7:1] == 7'h03) begin ea = !b[0]; ms = b[0] ? 7 : 4; end
                else if (model_hit(b)) begin ea = 1; ms = b[0] ? 3 : 2; end
                else ms = 7;
            end
            2: begin ev = 1; ea = 1; end
            4: begin ev = 1; ea = (b == 8'hA5); ms = ea ? 5 : 7; end
            5: begin ev = 1; ea = (b == 8'h5A); ms = ea ? 6 : 7; end
            6: begin ev = 1; ea = 0; ms = 7; end
            default: ;
        endcase
        @(negedge clk);
        byte_vld_i = 1'b1;
        byte_i = b;
        @(negedge clk);
        byte_vld_i = 1'b0;
        check(ack_vld_o == ev && ack_o == ea, tag, {ack_vld_o, ack_o}, {ev, ea});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog R10 actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed = 32'h1F2E;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check(ack_vld_o == 0 && ack_o == 0 && reg_rst_o == 0, "R10 reset state", {ack_vld_o, ack_o, reg_rst_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        send_byte(8'hC4, "R9 byte before start");
        // R1 both directions
        send_start(); send_byte(8'hC4, "R1 write"); send_byte(8'h11, "R9 write data"); send_stop("R1");
        send_start(); send_byte(8'hC5, "R1 read"); send_byte(8'h22, "R9 read data silent"); send_stop("R1");
        // R2 broadcast, register bit0 = 1
        send_start(); send_byte(8'hE0, "R2 disabled"); send_stop("R2");
        bcast_en_i = 1;
        send_start(); send_byte(8'hE0, "R2 enabled"); send_stop("R2");
        // R3 groups
        send_start(); send_byte(8'hE4, "R3 disabled"); send_stop("R3");
        grp_en_i = 3'b010;
        send_start(); send_byte(8'hE4, "R3 enabled"); send_stop("R3");
        send_start(); send_byte(8'hE8, "R3 other disabled"); send_byte(8'h33, "R9 after reject"); send_stop("R3");
        // R11 overlap: group 0 also equals broadcast
        grp_addr_i[7:0] = 8'hE0; grp_en_i = 3'b011;
        send_start(); send_byte(8'hE0, "R11 multi match"); send_stop("R11");
        // R4
        send_start(); send_byte(8'h40, "R4 no match"); send_stop("R4");
        // R5 read of reset call, with group holding 06h
        grp_addr_i[23:16] = 8'h07; grp_en_i = 3'b111;
        send_start(); send_byte(8'h07, "R5 read refused"); send_stop("R5");
        // good key
        send_start(); send_byte(8'h06, "R5 write"); send_byte(8'hA5, "R6 key1");
        send_byte(8'h5A, "R7 key2"); send_stop("R8 good");
        // R6 wrong first
        send_start(); send_byte(8'h06, "R5 write"); send_byte(8'h5A, "R6 wrong key1"); send_stop("R6");
        // R7 wrong second
        send_start(); send_byte(8'h06, "R5 write"); send_byte(8'hA5, "R6 key1");
        send_byte(8'hA5, "R7 wrong key2"); send_stop("R7");
        // R8 extra byte
        send_start(); send_byte(8'h06, "R5"); send_byte(8'hA5, "R6"); send_byte(8'h5A, "R7");
        send_byte(8'h00, "R8 extra byte"); send_stop("R8 extra");
        // R8 repeated start cancels
        send_start(); send_byte(8'h06, "R5"); send_byte(8'hA5, "R6"); send_byte(8'h5A, "R7");
        send_start(); send_byte(8'hC4, "R1 after restart"); send_stop("R8 restart");
        // random
        for (int t = 0; t < 400; t++) begin
            int k = $urandom_range(0, 5);
            int nd = $urandom_range(0, 3);
            logic [7:0] a;
            if ($urandom_range(0, 9) == 0) begin
                bcast_en_i = 1'($urandom); grp_en_i = 3'($urandom);
                bcast_addr_i = 8'($urandom); grp_addr_i = 24'($urandom);
            end
            case (k)
                0: a = {hw_addr_i, 1'b0};
                1: a = bcast_addr_i;
                2: a = grp_addr_i[8*$urandom_range(0, NG-1) +: 8];
                3: a = 8'h06;
                default: a = 8'($urandom);
            endcase
            a[0] = 1'($urandom);
            if ($urandom_range(0, 3) != 0 && k == 3) a[0] = 0;
            send_start();
            send_byte(a, "R1 R4 R5 random addr");
            for (int j = 0; j < nd; j++) begin
                logic [7:0] b;
                b = (j == 0 && $urandom_range(0, 3) != 0) ? 8'hA5 :
                    (j == 1 && $urandom_range(0, 3) != 0) ? 8'h5A : 8'($urandom);
                send_byte(b, "R6 R7 R9 random data");
            end
            if ($urandom_range(0, 4) != 0) send_stop("R8 random");
        end
        send_stop("R8 final");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule